// File: doc/BRIEF.md
# Outer-Totalistic Cellular Automaton Engine (B2/S2345)

This block holds a two-dimensional grid of one-bit cells and advances the whole grid by one generation per clock while a run is in progress. A dead cell comes alive when exactly two of its eight surrounding cells are alive. A live cell stays alive when two, three, four or five of them are alive. Every cell outside the grid counts as dead. Every cell is updated together from the previous generation, so no cell ever sees a partly updated neighbourhood.

A host writes a starting pattern one row per transfer, then starts a run of N generations. It then reads the grid back one row per request. A generation counter and a registered live-cell population are always visible on the ports.

Loading and reading use valid/ready handshakes. A transfer happens on a clock edge where valid and ready are both high. Every handshake is refused for the whole of a run. The read response has its own valid/ready pair. While the host holds the response ready low, the response stays valid and unchanged, and no new read request is accepted.

Top module: `ca_life_engine`

## Requirements
- R1: A dead cell becomes live in the next generation only when exactly two of its eight neighbours are live.
- R2: A live cell stays live when it has 2 to 5 live neighbours inclusive. With any other count it is dead in the next generation.
- R3: Positions outside the grid count as dead. They are not wrapped, so a fully live grid keeps only its border cells after one generation.
- R4: All cells switch together from the previous generation. Running N generations gives the same grid as applying the rule N times to the whole grid.
- R5: `ld_ready` is high exactly while no run is in progress. A load transfer writes `ld_bits` to row `ld_row`, with bit c of the word being column c. A load offered during a run changes nothing.
- R6: `rd_ready` is high when idle and the response slot is empty or being drained. An accepted request for row k makes `rsp_valid` high on the next cycle, with `rsp_bits` equal to row k, bit c being column c. While `rsp_ready` is low, `rsp_valid` and `rsp_bits` stay unchanged.
- R7: `step_go` with `step_n` = N > 0 while idle makes `busy` high for exactly N cycles, and one generation is committed per busy cycle. `step_go` with N = 0, or any `step_go` during a run, is ignored.
- R8: `done` is a one-cycle pulse in the cycle right after the last generation of a run is committed. `busy` is low in that same cycle.
- R9: `gen_count` increases by one for each committed generation, is unchanged otherwise, and is zero after reset.
- R10: `live_count` is a register. One cycle after any change to the grid, it equals the number of live cells.
- R11: After reset all cells are dead, `busy` and `done` are low, and both counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Row load offered |
| ld_ready | output | 1 | Row load can be accepted |
| ld_row | input | RW | Row index to write |
| ld_bits | input | COLS | Row contents, bit c is column c |
| rd_valid | input | 1 | Row read request offered |
| rd_ready | output | 1 | Read request can be accepted |
| rd_row | input | RW | Row index to read |
| rsp_valid | output | 1 | Read response holds data |
| rsp_ready | input | 1 | Host takes the response |
| rsp_bits | output | COLS | Row read back, bit c is column c |
| step_go | input | 1 | Start a run |
| step_n | input | STEP_W | Number of generations in the run |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse after the last generation |
| gen_count | output | GEN_W | Generations committed since reset |
| live_count | output | POP_W | Registered live-cell population |

## Verification
The hardest conditions to reach are commands that land in the middle of a run. These are a second start and a row load that both arrive while generations are being committed. To create them, the bench raises `step_go` with a different count and offers a full row of live cells on the first busy cycle. It then checks that the run length, the final grid and the counter all match an uninterrupted run. Boundary handling is only exposed when live cells touch the edge, so a fully live grid is loaded and stepped once, and the kept border is compared with what a null boundary predicts. Response back-pressure is held for several cycles so that the stability of the response and the refusal of new requests can both be observed.

// File: rtl/ca_pkg.sv
package ca_pkg;
  localparam int unsigned NBR_N = 8;
  localparam int unsigned NBR_CW = 4;
  // rule sets indexed by live-neighbour count 0..8
  localparam logic [8:0] BIRTH_DEFAULT   = 9'b0_0000_0100;
  localparam logic [8:0] SURVIVE_DEFAULT = 9'b0_0011_1100;
endpackage

// File: rtl/ca_cell_rule.sv
module ca_cell_rule
  import ca_pkg::*;
#(
  parameter logic [8:0] BIRTH_SET   = BIRTH_DEFAULT,
  parameter logic [8:0] SURVIVE_SET = SURVIVE_DEFAULT
) (
  input  logic             alive,
  input  logic [NBR_N-1:0] nbrs,
  output logic             next_alive
);
  logic [NBR_CW-1:0] cnt;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NBR_N; i++) cnt = cnt + NBR_CW'(nbrs[i]);
  end

  assign next_alive = alive ? SURVIVE_SET[cnt] : BIRTH_SET[cnt];
endmodule

// File: rtl/ca_cell_array.sv
module ca_cell_array #(
  parameter int unsigned ROWS = 32,
  parameter int unsigned COLS = 32,
  localparam int unsigned RW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [RW-1:0]             wr_row,
  input  logic [COLS-1:0]           wr_bits,
  input  logic                      adv_en,
  output logic [ROWS-1:0][COLS-1:0] cells
);
  // grid surrounded by a ring of permanently dead cells
  logic [ROWS+1:0][COLS+1:0] ring;
  logic [ROWS-1:0][COLS-1:0] nxt;

  always_comb begin
    ring = '0;
    for (int r = 0; r < int'(ROWS); r++)
      for (int c = 0; c < int'(COLS); c++)
        ring[r+1][c+1] = cells[r][c];
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      logic [7:0] nb;
      assign nb = {ring[r][c],   ring[r][c+1],   ring[r][c+2],
                   ring[r+1][c],                 ring[r+1][c+2],
                   ring[r+2][c], ring[r+2][c+1], ring[r+2][c+2]};
      ca_cell_rule u_rule (
        .alive      (cells[r][c]),
        .nbrs       (nb),
        .next_alive (nxt[r][c])
      );
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cells <= '0;
    else if (adv_en) cells <= nxt;
    else if (wr_en)  cells[wr_row] <= wr_bits;
  end
endmodule

// File: rtl/ca_popcount.sv
module ca_popcount #(
  parameter int unsigned N = 1024,
  localparam int unsigned PW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  bits,
  output logic [PW-1:0] total
);
  logic [PW-1:0] sum;

  always_comb begin
    sum = '0;
    for (int i = 0; i < int'(N); i++) sum = sum + PW'(bits[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) total <= '0;
    else        total <= sum;
  end
endmodule

// File: rtl/ca_step_ctrl.sv
module ca_step_ctrl #(
  parameter int unsigned STEP_W = 16,
  parameter int unsigned GEN_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [STEP_W-1:0] n_gen,
  output logic              busy,
  output logic              done,
  output logic [GEN_W-1:0]  gen
);
  logic [STEP_W-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      left <= '0;
      gen  <= '0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        gen  <= gen + 1'b1;
        left <= left - 1'b1;
        if (left == STEP_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else if (go && n_gen != '0) begin
        busy <= 1'b1;
        left <= n_gen;
      end
    end
  end
endmodule

// File: rtl/ca_life_engine.sv
module ca_life_engine #(
  parameter int unsigned ROWS   = 32,
  parameter int unsigned COLS   = 32,
  parameter int unsigned STEP_W = 16,
  parameter int unsigned GEN_W  = 32,
  localparam int unsigned RW    = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int unsigned CELLS = ROWS * COLS,
  localparam int unsigned POP_W = $clog2(CELLS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [RW-1:0]     ld_row,
  input  logic [COLS-1:0]   ld_bits,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [RW-1:0]     rd_row,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [COLS-1:0]   rsp_bits,
  input  logic              step_go,
  input  logic [STEP_W-1:0] step_n,
  output logic              busy,
  output logic              done,
  output logic [GEN_W-1:0]  gen_count,
  output logic [POP_W-1:0]  live_count
);
  logic [ROWS-1:0][COLS-1:0] cells;
  logic [CELLS-1:0]          flat;
  logic                      ld_fire;
  logic                      rd_fire;

  assign ld_ready = !busy;
  assign ld_fire  = ld_valid && ld_ready;
  assign rd_ready = !busy && (!rsp_valid || rsp_ready);
  assign rd_fire  = rd_valid && rd_ready;
  assign flat     = cells;

  ca_step_ctrl #(.STEP_W(STEP_W), .GEN_W(GEN_W)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (step_go),
    .n_gen (step_n),
    .busy  (busy),
    .done  (done),
    .gen   (gen_count)
  );

  ca_cell_array #(.ROWS(ROWS), .COLS(COLS)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ld_fire),
    .wr_row  (ld_row),
    .wr_bits (ld_bits),
    .adv_en  (busy),
    .cells   (cells)
  );

  ca_popcount #(.N(CELLS)) u_pop (
    .clk   (clk),
    .rst_n (rst_n),
    .bits  (flat),
    .total (live_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_bits  <= '0;
    end else if (rd_fire) begin
      rsp_valid <= 1'b1;
      rsp_bits  <= cells[rd_row];
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ca_life_engine_chk.sv
module ca_life_engine_chk #(
  parameter int unsigned STEP_W = 16,
  parameter int unsigned GEN_W  = 32,
  parameter int unsigned COLS   = 32,
  parameter int unsigned CELLS  = 1024,
  parameter int unsigned POP_W  = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_ready,
  input logic              rd_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [COLS-1:0]   rsp_bits,
  input logic              step_go,
  input logic [STEP_W-1:0] step_n,
  input logic              busy,
  input logic              done,
  input logic [GEN_W-1:0]  gen_count,
  input logic [POP_W-1:0]  live_count
);
  a_r5_r6_no_accept_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!ld_ready && !rd_ready));
  a_r7_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && step_go && step_n != '0) |=> busy);
  a_r7_zero_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (!step_go || step_n == '0)) |=> !busy);
  a_r8_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_gen_advance: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> gen_count == GEN_W'($past(gen_count) + 1'b1));
  a_r9_gen_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(gen_count));
  a_r6_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_bits)));
  a_r10_pop_bound: assert property (@(posedge clk) disable iff (!rst_n)
    live_count <= POP_W'(CELLS));
endmodule

bind ca_life_engine ca_life_engine_chk #(
  .STEP_W(STEP_W), .GEN_W(GEN_W), .COLS(COLS), .CELLS(CELLS), .POP_W(POP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_ready(ld_ready), .rd_ready(rd_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_bits(rsp_bits),
  .step_go(step_go), .step_n(step_n), .busy(busy), .done(done),
  .gen_count(gen_count), .live_count(live_count)
);

// File: tb/ca_life_engine_test.sv
`timescale 1ns/1ps
module ca_life_engine_test;
  localparam int R = 32;
  localparam int C = 32;
  localparam int SW = 16;
  localparam int GW = 32;
  localparam int PW = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_valid = 0, rd_valid = 0, rsp_ready = 1, step_go = 0;
  logic [4:0] ld_row = '0, rd_row = '0;
  logic [C-1:0] ld_bits = '0;
  logic [SW-1:0] step_n = '0;
  logic ld_ready, rd_ready, rsp_valid, busy, done;
  logic [C-1:0] rsp_bits;
  logic [GW-1:0] gen_count;
  logic [PW-1:0] live_count;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [C-1:0] refg [R];
  int exp_gen = 0;
  logic [31:0] lf = 32'h1234_5678;

  always #4 clk = ~clk;

  ca_life_engine uut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_row(ld_row), .ld_bits(ld_bits), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_row(rd_row), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_bits(rsp_bits),
    .step_go(step_go), .step_n(step_n), .busy(busy), .done(done),
    .gen_count(gen_count), .live_count(live_count)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic ref_step();
    logic [C-1:0] nx [R];
    for (int r = 0; r < R; r++)
      for (int c = 0; c < C; c++) begin
        int cnt = 0;
        for (int dr = -1; dr <= 1; dr++)
          for (int dc = -1; dc <= 1; dc++)
            if ((dr != 0 || dc != 0) && r+dr >= 0 && r+dr < R && c+dc >= 0 && c+dc < C)
              cnt += int'(refg[r+dr][c+dc]);
        nx[r][c] = refg[r][c] ? (cnt >= 2 && cnt <= 5) : (cnt == 2);
      end
    for (int r = 0; r < R; r++) refg[r] = nx[r];
  endtask

  function automatic int ref_pop();
    int s = 0;
    for (int r = 0; r < R; r++) s += $countones(refg[r]);
    return s;
  endfunction

  task automatic load_row(int r, logic [C-1:0] b);
    @(negedge clk);
    ld_valid = 1; ld_row = 5'(r); ld_bits = b;
    while (!ld_ready) @(negedge clk);
    @(negedge clk);
    ld_valid = 0;
  endtask

  task automatic load_ref();
    for (int r = 0; r < R; r++) load_row(r, refg[r]);
    @(negedge clk);
  endtask

  task automatic read_row(int r, output logic [C-1:0] b);
    @(negedge clk);
    rsp_ready = 1; rd_valid = 1; rd_row = 5'(r);
    while (!rd_ready) @(negedge clk);
    @(negedge clk);
    rd_valid = 0;
    if (!rsp_valid) $display("FAIL R6: actual=rsp_valid 0 expected=1 (row %0d)", r);
    b = rsp_bits;
  endtask

  task automatic grid_check(string tag);
    int miss = 0, first = -1;
    logic [C-1:0] got, fgot;
    fgot = '0;
    for (int r = 0; r < R; r++) begin
      read_row(r, got);
      if (got !== refg[r]) begin
        miss++;
        if (first < 0) begin first = r; fgot = got; end
      end
    end
    total++;
    if (miss != 0) begin
      bad++;
      $display("FAIL %s: row %0d actual=%h expected=%h", tag, first, fgot, refg[first]);
    end
  endtask

  task automatic run_steps(int n, string tag);
    int cyc = 0;
    @(negedge clk);
    step_go = 1; step_n = SW'(n);
    @(negedge clk);
    step_go = 0;
    while (busy && cyc < 100000) begin cyc++; @(negedge clk); end
    for (int i = 0; i < n; i++) ref_step();
    exp_gen += n;
    chk({tag, " R7 busy cycles"}, 64'(cyc), 64'(n));
    chk({tag, " R8 done high"}, 64'(done), 64'd1);
    @(negedge clk);
    chk({tag, " R8 done pulse ends"}, 64'(done), 64'd0);
    chk({tag, " R9 gen count"}, 64'(gen_count), 64'(exp_gen));
    chk({tag, " R10 population"}, 64'(live_count), 64'(ref_pop()));
  endtask

  task automatic t_reset();
    for (int r = 0; r < R; r++) refg[r] = '0;
    chk("R11 busy", 64'(busy), 0);
    chk("R11 done", 64'(done), 0);
    chk("R11 gen", 64'(gen_count), 0);
    chk("R11 pop", 64'(live_count), 0);
    grid_check("R11 grid dead");
  endtask

  task automatic t_pair();
    for (int r = 0; r < R; r++) refg[r] = '0;
    refg[10][10] = 1; refg[10][11] = 1;
    load_ref();
    chk("R5 load pop", 64'(live_count), 2);
    run_steps(1, "pair");
    // pair dies (one neighbour each), four cells with two neighbours are born
    chk("R2 pair cells die", 64'({refg[10][10], refg[10][11]}), 0);
    chk("R1 births count", 64'(live_count), 4);
    grid_check("R1 R2 pair step");
  endtask

  task automatic t_full();
    logic [C-1:0] got;
    for (int r = 0; r < R; r++) refg[r] = '1;
    load_ref();
    chk("R10 full pop", 64'(live_count), 1024);
    run_steps(1, "full");
    read_row(0, got);
    chk("R3 top edge kept", 64'(got), 64'(32'hFFFF_FFFF));
    read_row(5, got);
    chk("R3 interior row", 64'(got), 64'(32'h8000_0001));
    grid_check("R3 full grid");
  endtask

  task automatic t_random(int n);
    for (int r = 0; r < R; r++) begin
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      refg[r] = lf;
    end
    load_ref();
    run_steps(n, "random");
    grid_check("R4 random run");
  endtask

  task automatic t_ignore();
    int cyc = 0;
    int g0 = int'(gen_count);
    @(negedge clk); step_go = 1; step_n = 0;
    @(negedge clk); step_go = 0;
    repeat (3) begin
      if (busy) cyc++;
      @(negedge clk);
    end
    chk("R7 zero count ignored", 64'(cyc), 0);
    chk("R7 zero gen unchanged", 64'(gen_count), 64'(g0));
    // run 4, interfere in the middle
    @(negedge clk); step_go = 1; step_n = 4;
    @(negedge clk);
    step_go = 1; step_n = 9; ld_valid = 1; ld_row = 0; ld_bits = '1;
    cyc = 1;
    @(negedge clk);
    chk("R5 ld_ready low in run", 64'(ld_ready), 0);
    chk("R6 rd_ready low in run", 64'(rd_ready), 0);
    cyc++;
    step_go = 0; ld_valid = 0;
    @(negedge clk);
    while (busy && cyc < 1000) begin cyc++; @(negedge clk); end
    for (int i = 0; i < 4; i++) ref_step();
    exp_gen += 4;
    chk("R7 restart ignored", 64'(cyc), 4);
    @(negedge clk);
    chk("R9 gen after interfered run", 64'(gen_count), 64'(exp_gen));
    grid_check("R5 load in run ignored");
  endtask

  task automatic t_backpressure();
    logic [C-1:0] cap;
    @(negedge clk);
    rsp_ready = 0; rd_valid = 1; rd_row = 5'd7;
    @(negedge clk);
    rd_valid = 0;
    chk("R6 response valid", 64'(rsp_valid), 1);
    chk("R6 response data", 64'(rsp_bits), 64'(refg[7]));
    cap = rsp_bits;
    repeat (3) begin
      @(negedge clk);
      chk("R6 held under back-pressure", 64'({rsp_valid, rd_ready, rsp_bits}),
          64'({1'b1, 1'b0, cap}));
    end
    rsp_ready = 1;
    @(negedge clk);
    chk("R6 drained", 64'(rsp_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_pair();
    t_full();
    t_random(7);
    t_ignore();
    t_random(3);
    t_backpressure();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule